// File: doc/BRIEF.md
# Fixed-Latency Beacon Transmit Sequencer

This block runs the transmit side of a timing-master node that sends time beacons. A single start command enables the transmitter and launches a private microsecond timer, built by dividing the system clock by a power of two. When that timer reaches a first compare count, the block takes a snapshot of two external counters. These are a high-resolution free-running counter and a low-frequency counter, and the snapshot becomes the timestamp carried in the outgoing beacon. When the timer reaches a second, later compare count, the block pulses the radio start trigger. It then halts and clears its timer.

Both compare points are derived from the same clock. The number of cycles between taking the timestamp and starting transmission is therefore fixed by the parameters and never varies from run to run. A receiver can remove this constant delay as a known offset. The first compare count is chosen to cover the radio ramp-up time. The gap between the two compares gives downstream logic time to read the captured timestamp into the packet.

With the default parameters, the system clock is divided by 16 to give 1 µs ticks. The capture happens at tick 40 and the trigger at tick 50.

Top module: `bts_beacon_seq`

## Requirements
- R1: While reset is asserted and directly after reset, tx_en_o, cap_strobe_o, radio_go_o and stamp_valid_o are 0, and both timestamp outputs read 0.
- R2: A start_i sampled high while the block is idle is accepted. tx_en_o goes high on that same clock edge and stays high through the cycle in which radio_go_o is asserted.
- R3: The timer advances one tick every 2^PRESC_EXP clocks, counted from the accepting edge. cap_strobe_o is a one-cycle pulse that rises exactly CMP0·2^PRESC_EXP clocks after the accepting edge.
- R4: On the edge where cap_strobe_o rises, stamp_hi_o loads the value of hf_cnt_i and stamp_lo_o loads the value of lf_cnt_i, both sampled at that edge. Both outputs are signed, two's complement, and STAMP_W bits wide.
- R5: stamp_valid_o clears on the accepting edge and sets on the capture edge. It then stays high, and both timestamps hold their values, until the next accepted start.
- R6: radio_go_o is a one-cycle pulse exactly CMP1·2^PRESC_EXP clocks after the accepting edge. This is (CMP1−CMP0)·2^PRESC_EXP clocks after the capture. It occurs once per accepted start.
- R7: tx_en_o falls one clock after the radio_go_o pulse. The timer is then cleared, so a start sampled on the very next edge is accepted and repeats the same timing.
- R8: A start_i sampled high while a sequence is running, including in the radio_go_o cycle, is ignored. It causes no second capture and no second trigger, and it does not shift the timing of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz in the target use) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to run one beacon sequence |
| hf_cnt_i | input | STAMP_W | External high-resolution free-running counter |
| lf_cnt_i | input | STAMP_W | External low-frequency counter |
| tx_en_o | output | 1 | Transmitter enable, high while a sequence runs |
| cap_strobe_o | output | 1 | One-cycle pulse marking the timestamp capture |
| radio_go_o | output | 1 | One-cycle radio transmit start trigger |
| stamp_hi_o | output | STAMP_W | Captured high-resolution timestamp (signed) |
| stamp_lo_o | output | STAMP_W | Captured low-frequency timestamp (signed) |
| stamp_valid_o | output | 1 | Timestamps belong to the current or latest sequence |

## Verification
The bench measures the capture and trigger edges against the exact clock counts after the accepting edge. A prescaler that miscounts, or a compare that is off by one tick, moves a pulse by 16 cycles. A compare that is off by one clock moves it by a single cycle. The bench also applies start requests one cycle before the trigger and during the trigger cycle itself. A design that does not gate start correctly would then either restart the timer or emit a second trigger. Finally, the bench starts a new run on the first idle cycle after a run finishes. Counters that were not cleared would shorten that second run, and a valid flag that was not cleared would be high before the new capture.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_FIRE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bts_prescaler.sv
// Power-of-two clock divider producing a one-cycle tick enable.
module bts_prescaler #(
  parameter int PRESC_EXP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (PRESC_EXP < 1) ? 1 : PRESC_EXP;

  logic [PW-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q;
    if (clr_i)      div_d = '0;
    else if (run_i) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = run_i & ~clr_i & (div_q == {PW{1'b1}});

  // Ticks are never adjacent when dividing by two or more
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/bts_tick_timer.sv
// Tick counter with two compare points; stops and clears on the second.
module bts_tick_timer #(
  parameter int CMP0 = 40,
  parameter int CMP1 = 50,
  parameter int CW   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic hit0_o,
  output logic hit1_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign hit0_o = tick_i & (cnt_q == CW'(CMP0 - 1));
  assign hit1_o = tick_i & (cnt_q == CW'(CMP1 - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || hit1_o) cnt_d = '0;
    else if (tick_i)     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The count never reaches the second compare value: it wraps to zero there
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < CMP1);
  // A clear request leaves the counter at zero on the next cycle
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/bts_stamp_reg.sv
// Holds the captured timestamp pair and its valid flag.
module bts_stamp_reg #(
  parameter int STAMP_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      cap_i,
  input  logic signed [STAMP_W-1:0] hi_i,
  input  logic signed [STAMP_W-1:0] lo_i,
  output logic signed [STAMP_W-1:0] hi_o,
  output logic signed [STAMP_W-1:0] lo_o,
  output logic                      valid_o
);
  logic signed [STAMP_W-1:0] hi_q, lo_q;
  logic                      vld_q, vld_d;

  always_comb begin
    vld_d = vld_q;
    if (clr_i)      vld_d = 1'b0;
    else if (cap_i) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (cap_i) begin
        hi_q <= hi_i;
        lo_q <= lo_i;
      end
    end
  end

  assign hi_o    = hi_q;
  assign lo_o    = lo_q;
  assign valid_o = vld_q;

  // Stamps hold whenever no capture occurs
  assert_stamp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(hi_o) && $stable(lo_o));
  assert_stamp_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (hi_o == $past(hi_i)) && valid_o);
endmodule

// File: rtl/bts_beacon_seq.sv
// One-shot beacon transmit sequencer with fixed capture-to-trigger delay.
module bts_beacon_seq #(
  parameter int PRESC_EXP = 4,
  parameter int CMP0      = 40,
  parameter int CMP1      = 50,
  parameter int STAMP_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic signed [STAMP_W-1:0] hf_cnt_i,
  input  logic signed [STAMP_W-1:0] lf_cnt_i,
  output logic                      tx_en_o,
  output logic                      cap_strobe_o,
  output logic                      radio_go_o,
  output logic signed [STAMP_W-1:0] stamp_hi_o,
  output logic signed [STAMP_W-1:0] stamp_lo_o,
  output logic                      stamp_valid_o
);
  import bts_pkg::*;

  localparam int CW = $clog2(CMP1 + 1);

  seq_state_e state_q, state_d;
  logic       tx_en_q, tx_en_d;
  logic       cap_q, go_q;
  logic       accept, run, tmr_clr, tick, hit0, hit1;

  assign accept  = (state_q == SEQ_IDLE) & start_i;
  assign run     = (state_q == SEQ_RUN);
  assign tmr_clr = ~run;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (accept) state_d = SEQ_RUN;
      SEQ_RUN:  if (hit1)   state_d = SEQ_FIRE;
      SEQ_FIRE:             state_d = SEQ_IDLE;
      default:              state_d = SEQ_IDLE;
    endcase
    tx_en_d = (state_d != SEQ_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tx_en_q <= 1'b0;
      cap_q   <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      tx_en_q <= tx_en_d;
      cap_q   <= hit0;
      go_q    <= hit1;
    end
  end

  bts_prescaler #(.PRESC_EXP(PRESC_EXP)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tmr_clr),
    .run_i  (run),
    .tick_o (tick)
  );

  bts_tick_timer #(.CMP0(CMP0), .CMP1(CMP1), .CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (tmr_clr),
    .tick_i (tick),
    .hit0_o (hit0),
    .hit1_o (hit1)
  );

  bts_stamp_reg #(.STAMP_W(STAMP_W)) u_stamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (accept),
    .cap_i   (hit0),
    .hi_i    (hf_cnt_i),
    .lo_i    (lf_cnt_i),
    .hi_o    (stamp_hi_o),
    .lo_o    (stamp_lo_o),
    .valid_o (stamp_valid_o)
  );

  assign tx_en_o      = tx_en_q;
  assign cap_strobe_o = cap_q;
  assign radio_go_o   = go_q;

  assert_strobe_in_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe_o |-> tx_en_o);
  assert_go_in_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    radio_go_o |-> tx_en_o);
  assert_valid_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en_o) |-> !stamp_valid_o);
  assert_go_after_stamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    radio_go_o |-> stamp_valid_o);
  assert_go_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    radio_go_o |=> !radio_go_o && !tx_en_o);
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_o && start_i) |=> !$fell(stamp_valid_o));
endmodule

// File: tb/bts_beacon_seq_tb.sv
module bts_beacon_seq_tb;
  localparam int EXP = 4;
  localparam int C0  = 40;
  localparam int C1  = 50;
  localparam int DIV = 1 << EXP;
  localparam int T0  = C0 * DIV;
  localparam int T1  = C1 * DIV;
  localparam int SW  = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic signed [SW-1:0] hf_cnt, lf_cnt;
  logic tx_en, cap_stb, go, vld;
  logic signed [SW-1:0] st_hi, st_lo;
  logic [2:0] lf_div;

  int checks = 0;
  int errors = 0;

  int first_cap, n_cap, first_go, n_go, tx_fall, tx_bad, vld_bad;
  logic signed [SW-1:0] exp_hi, exp_lo;

  always #2 clk = ~clk;

  bts_beacon_seq #(.PRESC_EXP(EXP), .CMP0(C0), .CMP1(C1), .STAMP_W(SW)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .hf_cnt_i      (hf_cnt),
    .lf_cnt_i      (lf_cnt),
    .tx_en_o       (tx_en),
    .cap_strobe_o  (cap_stb),
    .radio_go_o    (go),
    .stamp_hi_o    (st_hi),
    .stamp_lo_o    (st_lo),
    .stamp_valid_o (vld)
  );

  // External counters: high-resolution one wraps through the sign change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hf_cnt <= 32'sh7FFF_FC00;
      lf_cnt <= -32'sd5;
      lf_div <= '0;
    end else begin
      hf_cnt <= hf_cnt + 1;
      lf_div <= lf_div + 1'b1;
      if (lf_div == 3'd6) begin
        lf_div <= '0;
        lf_cnt <= lf_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Raise start at a negedge; return at the negedge after the accepting edge (n=0)
  task automatic launch();
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Observe n = 0 .. win-1 negedges; inject start pulses at inj_a / inj_b
  task automatic observe(input int win, input int inj_a, input int inj_b);
    first_cap = -1; n_cap = 0; first_go = -1; n_go = 0;
    tx_fall = -1; tx_bad = 0; vld_bad = 0;
    for (int n = 0; n < win; n++) begin
      start_i = (n == inj_a) || (n == inj_b);
      if (cap_stb) begin n_cap++; if (first_cap < 0) first_cap = n; end
      if (go)      begin n_go++;  if (first_go < 0)  first_go  = n; end
      if (n <= T1 && !tx_en) tx_bad++;
      if (n > T1 && !tx_en && tx_fall < 0) tx_fall = n;
      if (vld !== (n >= T0)) vld_bad++;
      if (n == T0 - 1) begin exp_hi = hf_cnt; exp_lo = lf_cnt; end
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  task automatic check_run(input string tag);
    check(tx_bad == 0, "R2", {tag, " tx_en low during run"}, tx_bad, 0);
    check(first_cap == T0, "R3", {tag, " capture strobe cycle"}, first_cap, T0);
    check(n_cap == 1, "R3", {tag, " capture strobe count"}, n_cap, 1);
    check(st_hi == exp_hi, "R4", {tag, " high-res stamp"}, st_hi, exp_hi);
    check(st_lo == exp_lo, "R4", {tag, " low-freq stamp"}, st_lo, exp_lo);
    check(vld_bad == 0, "R5", {tag, " valid flag timing"}, vld_bad, 0);
    check(first_go == T1, "R6", {tag, " trigger cycle"}, first_go, T1);
    check(n_go == 1, "R6", {tag, " trigger count"}, n_go, 1);
    check(first_go - first_cap == T1 - T0, "R6", {tag, " capture-to-trigger gap"},
          first_go - first_cap, T1 - T0);
    check(tx_fall == T1 + 1, "R7", {tag, " tx_en fall cycle"}, tx_fall, T1 + 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!tx_en && !cap_stb && !go && !vld, "R1", "control outputs in reset",
          {tx_en, cap_stb, go, vld}, 0);
    check(st_hi == 0 && st_lo == 0, "R1", "stamps in reset", st_hi, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!tx_en && !go && !vld, "R1", "idle after reset", {tx_en, go, vld}, 0);
  endtask

  task automatic t_basic();
    logic signed [SW-1:0] h, l;
    launch();
    observe(T1 + 4, -1, -1);
    check_run("basic");
    h = st_hi; l = st_lo;
    repeat (40) @(negedge clk);
    check(st_hi == h && st_lo == l, "R5", "stamps hold while idle", st_hi, h);
    check(vld, "R5", "valid holds while idle", vld, 1);
  endtask

  task automatic t_busy_start();
    launch();
    observe(T1 + 4, T1 - 1, T1);
    check_run("busy");
    repeat (T1) @(negedge clk);
    check(!tx_en && !go, "R8", "no run started by ignored start", tx_en, 0);
    launch();
    observe(T1 + 4, 100, T0);
    check(n_go == 1 && first_go == T1, "R8", "mid-run start ignored", first_go, T1);
    check(n_cap == 1 && first_cap == T0, "R8", "no second capture", n_cap, 1);
  endtask

  task automatic t_back_to_back();
    launch();
    observe(T1 + 2, -1, -1);
    check_run("b2b-first");
    launch();
    observe(T1 + 4, -1, -1);
    check_run("b2b-second");
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    t_basic();
    t_busy_start();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule